// File: doc/BRIEF.md
# Sequenced Signed 16x16 Multiplier

This block multiplies two 16-bit operands over several clock cycles. It has one unsigned 8x8 multiplier that completes in a single cycle, and it reuses that multiplier once for each pair of operand bytes. The four byte products are summed in a 32-bit accumulator with full carry. When the operands are to be read as two's complement, the block corrects the upper half of the sum with up to two conditional subtractions. It does not use a signed multiplier array.

A byte mode multiplies only the low bytes of the two operands and returns a 16-bit product. This product can also be signed, and the same subtract-on-sign-bit correction is then applied to the upper byte of the product. A caller pulses `start` while the block is idle, waits for the one-cycle `done` pulse, and reads `result`. The number of cycles each operation takes depends only on the mode.

Top module: `seqmul16`

## Requirements
- R1: A request is accepted on a rising clock edge where `start` is 1 and `busy` is 0. The operands and both mode inputs are captured at that edge, and `busy` reads 1 from the next cycle.
- R2: A `start` pulse while `busy` is 1 is ignored. Operand and mode changes while `busy` is 1 are also ignored. The running operation finishes with the values captured at R1 and with its normal latency.
- R3: Unsigned 16x16 mode (`signed_mode`=0, `byte_mode`=0): `result` equals op_a*op_b as unsigned numbers (32 bits). `done` goes high 4 cycles after the accepting edge.
- R4: Signed 16x16 mode (`signed_mode`=1, `byte_mode`=0): `result` is the 32-bit two's complement product of op_a and op_b. `done` goes high 6 cycles after acceptance, whatever the sign bits are.
- R5: Unsigned byte mode (`byte_mode`=1, `signed_mode`=0): result[15:0] equals op_a[7:0]*op_b[7:0] and result[31:16] is 0. `done` goes high 1 cycle after acceptance, and op_a[15:8] and op_b[15:8] have no effect.
- R6: Signed byte mode (`byte_mode`=1, `signed_mode`=1): result[15:0] is the 16-bit two's complement product of op_a[7:0] and op_b[7:0], and result[31:16] is 0. `done` goes high 3 cycles after acceptance.
- R7: `done` is high for exactly one cycle per operation, and `busy` is 0 in that cycle. A `start` given in that same cycle is accepted.
- R8: `result` changes only at the edge that raises `done`. Between completions it holds its value, both while `busy` is 1 and while the block is idle.
- R9: While reset (`rst_n`=0) is applied and after it is released, `busy` is 0, `done` is 0 and `result` is 0 until an operation completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a multiply; taken only while idle |
| signed_mode | input | 1 | 1 = operands are two's complement |
| byte_mode | input | 1 | 1 = multiply low bytes only, 16-bit product |
| op_a | input | 16 | First operand |
| op_b | input | 16 | Second operand |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse when result is updated |
| result | output | 32 | Product of the last completed operation |

## Verification
Take the edge that accepts a request as edge 0. `done` and the new `result` then become visible after edge 1 for unsigned byte mode, edge 3 for signed byte mode, edge 4 for unsigned 16x16 mode and edge 6 for signed 16x16 mode. `busy` is visible after edge 0.

The bench model counts those same edges with an integer countdown. It holds the pending product, computed with native integer multiplication, and releases it only when the countdown reaches zero. The bench drives inputs and compares `busy`, `done` and `result` on falling edges, every cycle.

Each directed operation also counts the falling edges up to `done` and checks that count against the latency of its mode. Requests are also raised while the block is busy and in the same cycle as `done`, to check that `start` is refused in the first case and taken in the second.

// File: rtl/seqmul_pkg.sv
package seqmul_pkg;

  localparam int HALF_W = 8;
  localparam int OP_W   = 2 * HALF_W;
  localparam int RES_W  = 2 * OP_W;
  localparam int LAT_W  = 3;

  typedef enum logic [2:0] {
    PH_LL   = 3'd0,
    PH_HH   = 3'd1,
    PH_LH   = 3'd2,
    PH_HL   = 3'd3,
    PH_FIXB = 3'd4,
    PH_FIXA = 3'd5
  } phase_e;

  // Cycles from acceptance to done, per mode.
  function automatic logic [LAT_W-1:0] op_latency(input logic sgn, input logic byt);
    if (byt) return sgn ? LAT_W'(3) : LAT_W'(1);
    return sgn ? LAT_W'(6) : LAT_W'(4);
  endfunction

  function automatic logic is_last(input phase_e ph, input logic sgn, input logic byt);
    if (sgn)  return ph == PH_FIXA;
    if (byt)  return ph == PH_LL;
    return ph == PH_HL;
  endfunction

  function automatic phase_e next_phase(input phase_e ph, input logic byt);
    case (ph)
      PH_LL:   return byt ? PH_FIXB : PH_HH;
      PH_HH:   return PH_LH;
      PH_LH:   return PH_HL;
      PH_HL:   return PH_FIXB;
      PH_FIXB: return PH_FIXA;
      default: return PH_LL;
    endcase
  endfunction

  // Subtract v from bits [31:16] when en is set.
  function automatic logic [RES_W-1:0] sub_upper(input logic [RES_W-1:0] acc,
                                                 input logic en,
                                                 input logic [OP_W-1:0] v);
    if (!en) return acc;
    return {acc[RES_W-1:OP_W] - v, acc[OP_W-1:0]};
  endfunction

  // Subtract v from bits [15:8] when en is set (byte mode).
  function automatic logic [RES_W-1:0] sub_byte1(input logic [RES_W-1:0] acc,
                                                 input logic en,
                                                 input logic [HALF_W-1:0] v);
    if (!en) return acc;
    return {acc[RES_W-1:OP_W], acc[OP_W-1:HALF_W] - v, acc[HALF_W-1:0]};
  endfunction

  function automatic logic [RES_W-1:0] acc_step(input phase_e ph,
                                                input logic [RES_W-1:0] acc,
                                                input logic [OP_W-1:0] prod,
                                                input logic [OP_W-1:0] a,
                                                input logic [OP_W-1:0] b,
                                                input logic byt);
    case (ph)
      PH_LL:   return {{OP_W{1'b0}}, prod};
      PH_HH:   return acc + {prod, {OP_W{1'b0}}};
      PH_LH,
      PH_HL:   return acc + {{HALF_W{1'b0}}, prod, {HALF_W{1'b0}}};
      PH_FIXB: return byt ? sub_byte1(acc, b[HALF_W-1], a[HALF_W-1:0])
                          : sub_upper(acc, b[OP_W-1], a);
      PH_FIXA: return byt ? sub_byte1(acc, a[HALF_W-1], b[HALF_W-1:0])
                          : sub_upper(acc, a[OP_W-1], b);
      default: return acc;
    endcase
  endfunction

endpackage

// File: rtl/seqmul_byte_core.sv
module seqmul_byte_core #(
  parameter int W = 8
) (
  input  logic [W-1:0]   x,
  input  logic [W-1:0]   y,
  output logic [2*W-1:0] p
);
  always_comb p = {{W{1'b0}}, x} * {{W{1'b0}}, y};
endmodule

// File: rtl/seqmul_ctrl.sv
module seqmul_ctrl
  import seqmul_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  logic   sgn_in,
  input  logic   byte_in,
  output logic   busy,
  output logic   done,
  output phase_e phase,
  output logic   sgn_q,
  output logic   byte_q,
  output logic   accept,
  output logic   finish
);

  always_comb begin
    accept = start & ~busy;
    finish = busy & is_last(phase, sgn_q, byte_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      phase  <= PH_LL;
      sgn_q  <= 1'b0;
      byte_q <= 1'b0;
    end else begin
      done <= finish;
      if (accept) begin
        busy   <= 1'b1;
        phase  <= PH_LL;
        sgn_q  <= sgn_in;
        byte_q <= byte_in;
      end else if (busy) begin
        if (finish) busy <= 1'b0;
        else        phase <= next_phase(phase, byte_q);
      end
    end
  end

  // Cycle counter kept for the latency assertion.
  logic [LAT_W-1:0] lat_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n)      lat_cnt <= '0;
    else if (accept) lat_cnt <= LAT_W'(1);
    else if (busy)   lat_cnt <= lat_cnt + LAT_W'(1);
  end

  assert_busy_after_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);

  // R3, R4, R5, R6: the finishing step lands on the mode's fixed cycle count
  assert_fixed_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
    finish |-> (lat_cnt == op_latency(sgn_q, byte_q)));

  assert_fix_only_signed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (phase == PH_FIXB || phase == PH_FIXA)) |-> sgn_q);

  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_done_follows_finish_R7: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> done);

endmodule

// File: rtl/seqmul_dp.sv
module seqmul_dp
  import seqmul_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               accept,
  input  logic               busy,
  input  logic               finish,
  input  phase_e             phase,
  input  logic               byte_q,
  input  logic [OP_W-1:0]    op_a_in,
  input  logic [OP_W-1:0]    op_b_in,
  output logic [RES_W-1:0]   result
);

  logic [OP_W-1:0]   a_q, b_q;
  logic [RES_W-1:0]  acc, acc_nx;
  logic [HALF_W-1:0] core_x, core_y;
  logic [OP_W-1:0]   core_p;

  always_comb begin
    case (phase)
      PH_HH:   begin core_x = a_q[OP_W-1:HALF_W]; core_y = b_q[OP_W-1:HALF_W]; end
      PH_LH:   begin core_x = a_q[HALF_W-1:0];    core_y = b_q[OP_W-1:HALF_W]; end
      PH_HL:   begin core_x = a_q[OP_W-1:HALF_W]; core_y = b_q[HALF_W-1:0];    end
      default: begin core_x = a_q[HALF_W-1:0];    core_y = b_q[HALF_W-1:0];    end
    endcase
  end

  seqmul_byte_core #(.W(HALF_W)) u_core (
    .x (core_x),
    .y (core_y),
    .p (core_p)
  );

  always_comb acc_nx = acc_step(phase, acc, core_p, a_q, b_q, byte_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_q    <= '0;
      b_q    <= '0;
      acc    <= '0;
      result <= '0;
    end else begin
      if (accept) begin
        a_q <= op_a_in;
        b_q <= op_b_in;
      end
      if (busy) acc <= acc_nx;
      if (finish)
        result <= byte_q ? {{OP_W{1'b0}}, acc_nx[OP_W-1:0]} : acc_nx;
    end
  end

  assert_operands_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !finish) |=> ($stable(a_q) && $stable(b_q)));

  assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !finish |=> $stable(result));

  assert_byte_upper_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (finish && byte_q) |=> (result[RES_W-1:OP_W] == '0));

endmodule

// File: rtl/seqmul16.sv
module seqmul16
  import seqmul_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               signed_mode,
  input  logic               byte_mode,
  input  logic [OP_W-1:0]    op_a,
  input  logic [OP_W-1:0]    op_b,
  output logic               busy,
  output logic               done,
  output logic [RES_W-1:0]   result
);

  phase_e phase;
  logic   sgn_q, byte_q, accept, finish;

  seqmul_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .sgn_in  (signed_mode),
    .byte_in (byte_mode),
    .busy    (busy),
    .done    (done),
    .phase   (phase),
    .sgn_q   (sgn_q),
    .byte_q  (byte_q),
    .accept  (accept),
    .finish  (finish)
  );

  seqmul_dp u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .accept  (accept),
    .busy    (busy),
    .finish  (finish),
    .phase   (phase),
    .byte_q  (byte_q),
    .op_a_in (op_a),
    .op_b_in (op_b),
    .result  (result)
  );

  assert_busy_done_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  assert_start_ignored_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(sgn_q) && $stable(byte_q));

endmodule

// File: tb/seqmul16_tb.sv
module seqmul16_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        signed_mode = 1'b0;
  logic        byte_mode = 1'b0;
  logic [15:0] op_a = '0;
  logic [15:0] op_b = '0;
  logic        busy, done;
  logic [31:0] result;

  int errors = 0;
  int checks = 0;
  string cur_req = "R9";

  always #2.5 clk = ~clk;

  seqmul16 u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .signed_mode(signed_mode),
    .byte_mode(byte_mode), .op_a(op_a), .op_b(op_b),
    .busy(busy), .done(done), .result(result)
  );

  function automatic logic [31:0] ref_prod(input logic [15:0] a, input logic [15:0] b,
                                           input bit sg, input bit by);
    longint x, y;
    if (by) begin
      x = sg ? longint'($signed(a[7:0])) : longint'(a[7:0]);
      y = sg ? longint'($signed(b[7:0])) : longint'(b[7:0]);
      return {16'h0, 16'(x * y)};
    end
    x = sg ? longint'($signed(a)) : longint'(a);
    y = sg ? longint'($signed(b)) : longint'(b);
    return 32'(x * y);
  endfunction

  function automatic int ref_lat(input bit sg, input bit by);
    if (by) return sg ? 3 : 1;
    return sg ? 6 : 4;
  endfunction

  // Behavioural reference: countdown plus pending value
  bit          m_busy = 0, m_done = 0;
  int          m_left = 0;
  logic [31:0] m_result = '0, m_pend = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_left = 0; m_result = '0;
    end else begin
      bit take;
      take = start && !m_busy;
      m_done = 0;
      if (m_busy) begin
        m_left--;
        if (m_left == 0) begin
          m_busy = 0; m_done = 1; m_result = m_pend;
        end
      end
      if (take) begin
        m_busy = 1;
        m_left = ref_lat(signed_mode, byte_mode);
        m_pend = ref_prod(op_a, op_b, signed_mode, byte_mode);
      end
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Cycle-by-cycle comparison with the model
  always @(negedge clk) begin
    if (rst_n) begin
      chk(cur_req, "busy",   {31'h0, busy},   {31'h0, m_busy});
      chk(cur_req, "done",   {31'h0, done},   {31'h0, m_done});
      chk(cur_req, "result", result, m_result);
    end
  end

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected<=100000 cycles", wd);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // One operation. b2b: already at a negedge (done cycle), start there.
  // poke: keep raising start with altered operands while busy.
  task automatic op(input logic [15:0] a, input logic [15:0] b, input bit sg, input bit by,
                    input string req, input bit b2b, input bit poke);
    int n;
    int lat;
    lat = ref_lat(sg, by);
    if (!b2b) @(negedge clk);
    cur_req = req;
    op_a = a; op_b = b; signed_mode = sg; byte_mode = by; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!done && n < 12) begin
      start = poke && (n <= lat - 2);
      if (poke) begin
        op_a = ~a; op_b = b ^ 16'h5A5A; signed_mode = ~sg; byte_mode = ~by;
      end
      @(negedge clk);
      n++;
    end
    start = 1'b0;
    chk(req, "latency", 32'(n), 32'(lat));
    chk(req, "product", result, ref_prod(a, b, sg, by));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9: outputs during reset
    chk("R9", "busy in reset", {31'h0, busy}, 32'h0);
    chk("R9", "done in reset", {31'h0, done}, 32'h0);
    chk("R9", "result in reset", result, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9", "busy after reset", {31'h0, busy}, 32'h0);

    // R1 / R3: unsigned 16x16
    op(16'h1234, 16'h5678, 0, 0, "R3", 0, 0);
    @(negedge clk);
    chk("R1", "idle after op", {31'h0, busy}, 32'h0);
    op(16'hFFFF, 16'hFFFF, 0, 0, "R3", 0, 0);
    chk("R3", "max unsigned", result, 32'hFFFE0001);
    op(16'h0000, 16'hABCD, 0, 0, "R3", 0, 0);

    // R4: signed 16x16
    op(16'hFFFF, 16'hFFFF, 1, 0, "R4", 0, 0);
    chk("R4", "-1*-1", result, 32'h00000001);
    op(16'h8000, 16'h8000, 1, 0, "R4", 0, 0);
    chk("R4", "min*min", result, 32'h40000000);
    op(16'h8000, 16'h7FFF, 1, 0, "R4", 0, 0);
    op(16'h1234, 16'hFEDC, 1, 0, "R4", 0, 0);
    op(16'h7FFF, 16'h7FFF, 1, 0, "R4", 0, 0);

    // R5: unsigned byte mode, upper operand bytes must not matter
    op(16'hAB12, 16'hCDFF, 0, 1, "R5", 0, 0);
    chk("R5", "low bytes only", result, 32'h000011EE);
    op(16'h00FF, 16'hFFFF, 0, 1, "R5", 0, 0);

    // R6: signed byte mode
    op(16'h0080, 16'h0080, 1, 1, "R6", 0, 0);
    chk("R6", "-128*-128", result, 32'h00004000);
    op(16'hFF80, 16'h0001, 1, 1, "R6", 0, 0);
    chk("R6", "-128*1", result, 32'h0000FF80);
    op(16'h12FF, 16'h347F, 1, 1, "R6", 0, 0);

    // R2: start and input changes while busy are ignored
    op(16'h8001, 16'hC003, 1, 0, "R2", 0, 1);
    op(16'h4321, 16'h00F0, 0, 0, "R2", 0, 1);

    // R7: start in the done cycle is accepted
    op(16'h0102, 16'h0304, 0, 1, "R7", 0, 0);
    op(16'hF00F, 16'h0FF0, 1, 0, "R7", 1, 0);
    op(16'h00C0, 16'h0003, 1, 1, "R7", 1, 0);

    // R8: result holds while idle with inputs changing
    cur_req = "R8";
    for (int i = 0; i < 6; i++) begin
      op_a = 16'(i * 16'h1111); op_b = ~op_a; signed_mode = i[0]; byte_mode = i[1];
      @(negedge clk);
    end
    chk("R8", "held result", result, ref_prod(16'h00C0, 16'h0003, 1, 1));

    // Mixed operands across modes (R3, R4, R5, R6)
    for (int i = 0; i < 40; i++) begin
      logic [15:0] a, b;
      bit sg, by;
      a = 16'($urandom); b = 16'($urandom);
      sg = i[0]; by = i[1];
      op(a, b, sg, by, by ? (sg ? "R6" : "R5") : (sg ? "R4" : "R3"), 0, 0);
    end

    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule